// File: doc/BRIEF.md
# Rotor Position Detection Sampler

This block watches the three rotor position inputs of a brushless motor drive (U on bit 0, V on bit 1, W on bit 2). It takes a sample on a strobe derived from the core clock at one of four rates. Each sample is checked against a programmed pattern or, in the unmatch mode, against a snapshot of the inputs taken when sampling began. When enough consecutive samples qualify, the block emits a one-cycle detection pulse and a one-cycle interrupt request. It then either keeps sampling or, if a stop was requested, goes idle.

Sampling can run freely or can be limited to PWM-on time or to lower-side phase conduction. The PWM-on condition is the OR of the three phase PWM lines, and lower-side conduction is the OR of three conduction lines. In the two gated modes a programmable number of sample strobes is skipped after every PWM turn-on, so that switching noise is not sampled. Sampling is started by a software pulse or by an enabled timer trigger. It is stopped in the same two ways, but a stop takes effect only at the next detection. Two hold flags record whether a detection had already been seen at the latest PWM rising edge and at the latest PWM falling edge. Software reads them to place the detection relative to the PWM pulse.

Top module: `rotor_pos_sampler`

## Requirements
- R1: While `rst_n` is low or `en` is 0, `busy`, `det_pulse`, `irq`, `snap_pat`, `hold_rise` and `hold_fall` are all 0, and start requests have no effect. Enabling the block without a start request leaves it idle.
- R2: While busy, a sample strobe occurs every 4·2^`rate_sel` clocks. The first strobe comes that many clocks after `busy` rises, and no samples are taken while idle.
- R3: With `single_pin`=1 only bit 0 (U) is compared. Bits 1 and 2 of `pos_in`, `expect_pat` and the snapshot have no effect on detection.
- R4: In ordinary mode (`unmatch_mode`=0) a sample qualifies when `pos_in` equals `expect_pat`. On the sample that completes `need_m1`+1 consecutive qualifying samples, `det_pulse` and `irq` are both high for exactly the next clock. A non-qualifying sample restarts the run, and a detection also restarts it.
- R5: In unmatch mode (`unmatch_mode`=1) a sample qualifies when `pos_in` differs from `snap_pat`. Counting and pulse timing are the same as in R4.
- R6: While idle and enabled, `sw_start`=1 or (`tmr_start_en` & `tmr_start_trig`) makes `busy` high on the next clock and loads `snap_pat` with `pos_in`. The same start also clears both hold flags. A start request while busy, and a timer start with `tmr_start_en`=0, are ignored.
- R7: While busy, `sw_stop`=1 or (`tmr_stop_en` & `tmr_stop_trig`) does not stop sampling at once. `busy` falls in the same clock as the `det_pulse` of the next detection, including a detection in the request cycle itself.
- R8: `mode` selects sampling: 0 samples only while the OR of `pwm_in` is 1, 2 samples only while the OR of `low_in` is 1, and 1 or 3 sample on every strobe.
- R9: In modes 0 and 2, a PWM turn-on (OR of `pwm_in` rising) and a start each load a skip count from `start_delay`. Strobes are not sampled while that count is non-zero, and each strobe decrements it. A strobe in the turn-on clock itself is never sampled.
- R10: In mode 0 with `recount`=1, each PWM turn-off restarts the consecutive count. With `recount`=0 the count carries across PWM-off intervals.
- R11: At each rising edge of the combined PWM, `hold_rise` takes the value of the detection-seen flag, and at each falling edge `hold_fall` does. The flag is set by a detection and cleared by a start. The flag value used is the one from before that clock's detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Function enable; 0 holds the block idle and cleared |
| mode | input | 2 | 0 PWM-on, 1 free, 2 lower-side, 3 free |
| rate_sel | input | 2 | Strobe period 4·2^rate_sel clocks |
| need_m1 | input | 3 | Consecutive qualifying samples minus one |
| start_delay | input | 4 | Strobes skipped after PWM turn-on or start |
| unmatch_mode | input | 1 | 1 compares against the start snapshot |
| single_pin | input | 1 | 1 compares U only |
| recount | input | 1 | Restart count on PWM turn-off (mode 0) |
| expect_pat | input | 3 | Expected pattern, bit 0 U, bit 1 V, bit 2 W |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop request pulse |
| tmr_start_en | input | 1 | Allows timer start trigger |
| tmr_start_trig | input | 1 | Timer start trigger |
| tmr_stop_en | input | 1 | Allows timer stop trigger |
| tmr_stop_trig | input | 1 | Timer stop trigger |
| pos_in | input | 3 | Rotor position inputs U, V, W |
| pwm_in | input | 3 | Phase PWM signals |
| low_in | input | 3 | Lower-side phase conduction signals |
| det_pulse | output | 1 | One-clock detection pulse |
| irq | output | 1 | One-clock interrupt request |
| busy | output | 1 | Sampling active |
| snap_pat | output | 3 | Inputs captured at start |
| hold_rise | output | 1 | Detection seen at latest PWM rising edge |
| hold_fall | output | 1 | Detection seen at latest PWM falling edge |

## Verification
`busy`, `snap_pat` and the hold flags change on the first rising clock edge after their cause. `det_pulse` and `irq` appear one clock after the sample strobe that completes the run, and that strobe lands 4·2^`rate_sel` clocks after the previous one or after `busy` rises. The bench keeps a behavioural model that advances on the same rising edge from the same input values. It compares every output with the model on the falling edge, half a period after any change, so a result a clock early or late shows up as a mismatch. Inputs change only on falling edges.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;
    typedef enum logic [1:0] {
        SMODE_PWM_ON   = 2'd0,
        SMODE_FREE     = 2'd1,
        SMODE_LOW_SIDE = 2'd2,
        SMODE_FREE_ALT = 2'd3
    } smode_e;
endpackage

// File: rtl/rps_prescaler.sv
`timescale 1ns/1ps
module rps_prescaler #(
    parameter int RATE_W     = 2,
    parameter int BASE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tick
);
    localparam int DIV_W = BASE_SHIFT + (1 << RATE_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t             s_d, s_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = DIV_W'((32'd1 << (BASE_SHIFT + 32'(rate_sel))) - 32'd1);
        tick  = run && (s_q.div >= lim);
        s_d   = s_q;
        if (!run || tick) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("strobe on adjacent clocks"); // R2
endmodule

// File: rtl/rps_gate.sv
`timescale 1ns/1ps
module rps_gate
    import rps_pkg::*;
#(
    parameter int PH    = 3,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             load,
    input  logic             tick,
    input  smode_e           mode,
    input  logic [PH-1:0]    pwm_in,
    input  logic [PH-1:0]    low_in,
    input  logic [DLY_W-1:0] delay,
    output logic             samp,
    output logic             pwm_rise,
    output logic             pwm_fall
);
    typedef struct packed {
        logic             pwm_prev;
        logic [DLY_W-1:0] dly;
    } gate_t;

    gate_t s_d, s_q;
    logic  pwm_on;
    logic  gated;
    logic  cond;

    always_comb begin
        pwm_on   = |pwm_in;
        pwm_rise = en && pwm_on && !s_q.pwm_prev;
        pwm_fall = en && !pwm_on && s_q.pwm_prev;
        gated    = (mode == SMODE_PWM_ON) || (mode == SMODE_LOW_SIDE);
        unique case (mode)
            SMODE_PWM_ON:   cond = pwm_on;
            SMODE_LOW_SIDE: cond = |low_in;
            default:        cond = 1'b1;
        endcase
        samp = run && tick && cond && (!gated || ((s_q.dly == '0) && !pwm_rise));

        s_d          = s_q;
        s_d.pwm_prev = en && pwm_on;
        if (!en) begin
            s_d.dly = '0;
        end else if (load || (gated && pwm_rise)) begin
            s_d.dly = delay;
        end else if (run && tick && (s_q.dly != '0)) begin
            s_d.dly = s_q.dly - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_DELAY_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (load || (gated && pwm_rise))) |=> (s_q.dly == $past(delay)))
        else $error("skip count not loaded on turn-on"); // R9
endmodule

// File: rtl/rps_qualify.sv
`timescale 1ns/1ps
module rps_qualify #(
    parameter int PH    = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             samp,
    input  logic             restart,
    input  logic             unmatch,
    input  logic             single,
    input  logic [CNT_W-1:0] need,
    input  logic [PH-1:0]    pos,
    input  logic [PH-1:0]    ref_pat,
    output logic             det
);
    localparam int RUN_W = CNT_W + 1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } qual_t;

    qual_t         s_d, s_q;
    logic [PH-1:0] mask;
    logic          eq;
    logic          hit;

    for (genvar i = 0; i < PH; i++) begin : g_mask
        if (i == 0) begin : g_lead
            assign mask[i] = 1'b1;
        end else begin : g_rest
            assign mask[i] = !single;
        end
    end

    always_comb begin
        eq  = ((pos ^ ref_pat) & mask) == '0;
        hit = unmatch ? !eq : eq;
        det = samp && hit && (s_q.run >= {1'b0, need});

        s_d = s_q;
        if (clr) begin
            s_d.run = '0;
        end else if (samp) begin
            s_d.run = (hit && !det) ? s_q.run + 1'b1 : '0;
        end else if (restart) begin
            s_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run <= {1'b0, {CNT_W{1'b1}}}) else $error("run count overflow"); // R4
endmodule

// File: rtl/rotor_pos_sampler.sv
`timescale 1ns/1ps
module rotor_pos_sampler
    import rps_pkg::*;
#(
    parameter int PH         = 3,
    parameter int RATE_W     = 2,
    parameter int BASE_SHIFT = 2,
    parameter int CNT_W      = 3,
    parameter int DLY_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [CNT_W-1:0]  need_m1,
    input  logic [DLY_W-1:0]  start_delay,
    input  logic              unmatch_mode,
    input  logic              single_pin,
    input  logic              recount,
    input  logic [PH-1:0]     expect_pat,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              tmr_start_en,
    input  logic              tmr_start_trig,
    input  logic              tmr_stop_en,
    input  logic              tmr_stop_trig,
    input  logic [PH-1:0]     pos_in,
    input  logic [PH-1:0]     pwm_in,
    input  logic [PH-1:0]     low_in,
    output logic              det_pulse,
    output logic              irq,
    output logic              busy,
    output logic [PH-1:0]     snap_pat,
    output logic              hold_rise,
    output logic              hold_fall
);
    typedef struct packed {
        logic          busy;
        logic          stop_pend;
        logic [PH-1:0] snap;
        logic          seen;
        logic          hold_rise;
        logic          hold_fall;
        logic          det;
        logic          irq;
    } ctrl_t;

    ctrl_t         c_d, c_q;
    smode_e        mode_e;
    logic          tick;
    logic          samp;
    logic          pwm_rise;
    logic          pwm_fall;
    logic          det_s;
    logic          start_req;
    logic          stop_req;
    logic          start;
    logic          restart;
    logic          q_clr;
    logic [PH-1:0] ref_pat;

    assign mode_e    = smode_e'(mode);
    assign start_req = sw_start || (tmr_start_en && tmr_start_trig);
    assign stop_req  = sw_stop || (tmr_stop_en && tmr_stop_trig);
    assign start     = en && !c_q.busy && start_req;
    assign restart   = recount && (mode_e == SMODE_PWM_ON) && pwm_fall;
    assign q_clr     = start || !c_q.busy || !en;
    assign ref_pat   = unmatch_mode ? c_q.snap : expect_pat;

    rps_prescaler #(
        .RATE_W    (RATE_W),
        .BASE_SHIFT(BASE_SHIFT)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (c_q.busy),
        .rate_sel(rate_sel),
        .tick    (tick)
    );

    rps_gate #(
        .PH   (PH),
        .DLY_W(DLY_W)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .run     (c_q.busy),
        .load    (start),
        .tick    (tick),
        .mode    (mode_e),
        .pwm_in  (pwm_in),
        .low_in  (low_in),
        .delay   (start_delay),
        .samp    (samp),
        .pwm_rise(pwm_rise),
        .pwm_fall(pwm_fall)
    );

    rps_qualify #(
        .PH   (PH),
        .CNT_W(CNT_W)
    ) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (q_clr),
        .samp   (samp),
        .restart(restart),
        .unmatch(unmatch_mode),
        .single (single_pin),
        .need   (need_m1),
        .pos    (pos_in),
        .ref_pat(ref_pat),
        .det    (det_s)
    );

    always_comb begin
        c_d     = c_q;
        c_d.det = det_s;
        c_d.irq = det_s;
        if (pwm_rise) begin
            c_d.hold_rise = c_q.seen;
        end
        if (pwm_fall) begin
            c_d.hold_fall = c_q.seen;
        end
        if (c_q.busy && stop_req) begin
            c_d.stop_pend = 1'b1;
        end
        if (det_s) begin
            c_d.seen = 1'b1;
            if (c_q.stop_pend || stop_req) begin
                c_d.busy      = 1'b0;
                c_d.stop_pend = 1'b0;
            end
        end
        if (start) begin
            c_d.busy      = 1'b1;
            c_d.stop_pend = 1'b0;
            c_d.snap      = pos_in;
            c_d.seen      = 1'b0;
            c_d.hold_rise = 1'b0;
            c_d.hold_fall = 1'b0;
        end
        if (!en) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign det_pulse = c_q.det;
    assign irq       = c_q.irq;
    assign busy      = c_q.busy;
    assign snap_pat  = c_q.snap;
    assign hold_rise = c_q.hold_rise;
    assign hold_fall = c_q.hold_fall;

    AST_DET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(c_q.busy)) else $error("detection while idle"); // R4
    AST_STOP_AT_DET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(c_q.busy) && $past(en)) |-> det_pulse) else $error("stopped without detection"); // R7
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && $past(c_q.busy)) |-> $stable(c_q.snap)) else $error("snapshot changed while busy"); // R6
    AST_HOLD_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.busy) |-> (!hold_rise && !hold_fall)) else $error("holds not cleared at start"); // R11
endmodule

// File: tb/tb_rotor_pos_sampler.sv
`timescale 1ns/1ps
module tb_rotor_pos_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd1;
    logic [1:0] rate_sel = 2'd0;
    logic [2:0] need_m1 = 3'd0;
    logic [3:0] start_delay = 4'd0;
    logic       unmatch_mode = 1'b0, single_pin = 1'b0, recount = 1'b0;
    logic [2:0] expect_pat = 3'd0;
    logic       sw_start = 1'b0, sw_stop = 1'b0;
    logic       tmr_start_en = 1'b0, tmr_start_trig = 1'b0;
    logic       tmr_stop_en = 1'b0, tmr_stop_trig = 1'b0;
    logic [2:0] pos_in = 3'd0, pwm_in = 3'd0, low_in = 3'd0;
    logic       det_pulse, irq, busy, hold_rise, hold_fall;
    logic [2:0] snap_pat;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    pos_rand = 1'b0;
    int    pwm_ph = 0;
    int    pwm_sel = 0;
    string phase = "R1 reset state";

    always #2.5 clk = ~clk;

    rotor_pos_sampler dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .rate_sel(rate_sel),
        .need_m1(need_m1), .start_delay(start_delay), .unmatch_mode(unmatch_mode),
        .single_pin(single_pin), .recount(recount), .expect_pat(expect_pat),
        .sw_start(sw_start), .sw_stop(sw_stop), .tmr_start_en(tmr_start_en),
        .tmr_start_trig(tmr_start_trig), .tmr_stop_en(tmr_stop_en),
        .tmr_stop_trig(tmr_stop_trig), .pos_in(pos_in), .pwm_in(pwm_in),
        .low_in(low_in), .det_pulse(det_pulse), .irq(irq), .busy(busy),
        .snap_pat(snap_pat), .hold_rise(hold_rise), .hold_fall(hold_fall)
    );

    // behavioural reference
    logic       m_busy = 0, m_pend = 0, m_seen = 0, m_rh = 0, m_fh = 0, m_det = 0, m_prev = 0;
    logic [2:0] m_snap = 0;
    int         m_run = 0, m_div = 0, m_dly = 0;

    always @(posedge clk) begin
        logic pon, rise, fall, tk, gated, cond, smp, same, qual, dt, strt, stp;
        logic [2:0] msk, refp;
        int per;
        logic n_busy, n_pend, n_seen, n_rh, n_fh;
        logic [2:0] n_snap;
        int n_run, n_div, n_dly;
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; m_seen = 0; m_rh = 0; m_fh = 0; m_det = 0;
            m_prev = 0; m_snap = 0; m_run = 0; m_div = 0; m_dly = 0;
        end else begin
            pon   = |pwm_in;
            rise  = en && pon && !m_prev;
            fall  = en && !pon && m_prev;
            per   = 4 << int'(rate_sel);
            tk    = m_busy && (m_div >= per - 1);
            gated = (mode == 2'd0) || (mode == 2'd2);
            cond  = (mode == 2'd0) ? pon : ((mode == 2'd2) ? (|low_in) : 1'b1);
            smp   = tk && cond && (!gated || (m_dly == 0 && !rise));
            msk   = single_pin ? 3'b001 : 3'b111;
            refp  = unmatch_mode ? m_snap : expect_pat;
            same  = ((pos_in ^ refp) & msk) == 3'b000;
            qual  = unmatch_mode ? !same : same;
            dt    = smp && qual && (m_run >= int'(need_m1));
            strt  = en && !m_busy && (sw_start || (tmr_start_en && tmr_start_trig));
            stp   = sw_stop || (tmr_stop_en && tmr_stop_trig);

            n_run = m_run;
            if (strt || !m_busy) n_run = 0;
            else if (smp) n_run = (qual && !dt) ? m_run + 1 : 0;
            else if (recount && mode == 2'd0 && fall) n_run = 0;
            n_div = (!m_busy || tk) ? 0 : m_div + 1;
            n_dly = m_dly;
            if (strt || (gated && rise)) n_dly = int'(start_delay);
            else if (tk && m_dly > 0) n_dly = m_dly - 1;

            n_busy = m_busy; n_pend = m_pend; n_snap = m_snap;
            n_seen = m_seen; n_rh = m_rh; n_fh = m_fh;
            if (rise) n_rh = m_seen;
            if (fall) n_fh = m_seen;
            if (m_busy && stp) n_pend = 1;
            if (dt) begin
                n_seen = 1;
                if (m_pend || stp) begin n_busy = 0; n_pend = 0; end
            end
            if (strt) begin
                n_busy = 1; n_pend = 0; n_snap = pos_in; n_seen = 0; n_rh = 0; n_fh = 0;
            end
            m_det  = dt;
            m_prev = en && pon;
            if (!en) begin
                n_busy = 0; n_pend = 0; n_snap = 0; n_seen = 0; n_rh = 0; n_fh = 0;
                n_run = 0; n_div = 0; n_dly = 0; m_det = 0;
            end
            m_busy = n_busy; m_pend = n_pend; m_snap = n_snap; m_seen = n_seen;
            m_rh = n_rh; m_fh = n_fh; m_run = n_run; m_div = n_div; m_dly = n_dly;
        end
    end

    task automatic chk(string what, logic [2:0] act, logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("det_pulse", {2'b0, det_pulse}, {2'b0, m_det});
            chk("irq", {2'b0, irq}, {2'b0, m_det});
            chk("busy", {2'b0, busy}, {2'b0, m_busy});
            chk("snap_pat", snap_pat, m_snap);
            chk("hold_rise", {2'b0, hold_rise}, {2'b0, m_rh});
            chk("hold_fall", {2'b0, hold_fall}, {2'b0, m_fh});
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sw_start = 0; sw_stop = 0; tmr_start_trig = 0; tmr_stop_trig = 0;
            if (pos_rand && ($urandom % 32 == 0)) pos_in = 3'($urandom);
            pwm_ph = (pwm_ph + 1) % 40;
            if (pwm_ph == 0) pwm_sel = (pwm_sel + 1) % 3;
            pwm_in = (pwm_ph < 18) ? 3'(1 << pwm_sel) : 3'b000;
            low_in = (pwm_ph >= 22) ? 3'b010 : 3'b000;
        end
    endtask

    task automatic kick_start();
        sw_start = 1; step(1);
    endtask

    task automatic reinit();
        en = 0; step(2); en = 1;
    endtask

    initial begin
        step(4);
        rst_n = 1;
        step(6);
        phase = "R1 start ignored while disabled";
        kick_start(); step(6);
        en = 1; step(20);
        phase = "R6 timer start without enable";
        tmr_start_trig = 1; step(1); step(10);

        phase = "R2 strobe rate";
        mode = 2'd1; rate_sel = 2'd0; need_m1 = 3'd0; expect_pat = 3'b101; pos_in = 3'b101;
        kick_start(); step(60);
        rate_sel = 2'd1; step(80);
        rate_sel = 2'd3; step(150);
        phase = "R4 ordinary consecutive match";
        rate_sel = 2'd0; need_m1 = 3'd2; pos_rand = 1; step(600);
        phase = "R6 start while busy";
        kick_start(); step(30);
        phase = "R7 software stop waits for detection";
        sw_stop = 1; step(1); step(300);
        phase = "R6 timer start enabled";
        tmr_start_en = 1; tmr_start_trig = 1; step(1); step(100);
        phase = "R7 timer stop";
        tmr_stop_en = 1; tmr_stop_trig = 1; step(1); step(300);

        phase = "R3 single pin compare";
        reinit(); single_pin = 1; expect_pat = 3'b001; need_m1 = 3'd1;
        kick_start(); step(500); single_pin = 0;
        phase = "R5 unmatch against snapshot";
        reinit(); unmatch_mode = 1; kick_start(); step(600);
        sw_stop = 1; step(1); step(300); unmatch_mode = 0;

        phase = "R8 PWM-on gating";
        reinit(); mode = 2'd0; start_delay = 4'd0; expect_pat = 3'b011;
        kick_start(); step(800);
        phase = "R8 lower-side gating";
        mode = 2'd2; step(600);
        phase = "R9 turn-on delay";
        mode = 2'd0; start_delay = 4'd2; step(600);
        start_delay = 4'd9; step(400);
        phase = "R10 recount on";
        reinit(); start_delay = 4'd1; need_m1 = 3'd3; recount = 1; kick_start(); step(800);
        phase = "R10 recount off";
        recount = 0; step(800);

        phase = "R11 edge holds";
        reinit(); mode = 2'd1; need_m1 = 3'd0; pos_rand = 0; pos_in = 3'b011;
        kick_start(); sw_stop = 1; step(1); step(200);
        kick_start(); step(100);
        en = 0; step(3);
        phase = "R1 disabled clears";
        step(5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule